// File: doc/BRIEF.md
# Dual-Size Second-Level TLB with Hole Vectors

This block is a small, fully associative second-level translation cache that holds 4KB and 2MB translations side by side. Every lookup compares the requested 4KB virtual page number against both sizes at once. A 4KB entry can sit inside a 2MB mapping and mark a "hole" that is mapped on its own. When both sizes match, the 4KB entry is used.

Some entries store hole bits instead of a translation. Each such entry keeps a 32-bit slice of the per-page hole vector, so sixteen slices cover the 512 small pages of a 2MB region. A lookup that matches only a 2MB entry is a hit when two things hold: the slice covering the target page is resident, and its bit for that page is clear. The result is then a synthesized 4KB translation for filling the first-level TLB, with a flag set to mark it as synthesized. The first-level TLB returns that flag on eviction, and the block then ORs the evicted accessed and dirty bits into the parent 2MB entry.

Entries arrive from the page walker through a single fill port. A new entry takes a slot chosen by a round-robin pointer.

Top module: `dual_l2_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, and a miss drives lk_ppn, lk_synth, lk_acc and lk_dirty to zero.
- R2: A fill of kind 0 (4KB) stores fl_data[PPN_W-1:0] for page fl_vpn, and the fill takes effect at the next clock edge. After that, a lookup of that exact page hits combinationally with that PPN and lk_synth=0, and a lookup of a neighbouring page does not hit through that entry.
- R3: When a 4KB entry and a 2MB entry both match, the 4KB PPN is returned with lk_synth=0, whatever the hole bit says.
- R4: A fill of kind 1 (2MB) covers all pages whose vpn[19:9] equals fl_vpn[19:9]. A fill of kind 2 (hole slice) stores 32 hole bits for slice vpn[8:5] of page vpn[19:9], where bit k belongs to vpn[4:0]=k and a 1 marks a hole. A lookup that matches only a 2MB entry hits when the slice is resident and the target bit is 0.
- R5: A synthesized hit returns PPN {base[19:9], vpn[8:0]}, where base is the 2MB entry's stored PPN, and it sets lk_synth=1.
- R6: A 2MB-only match is a miss when the covering slice is absent or when the target hole bit is 1.
- R7: An eviction with ev_synth=1 ORs ev_acc and ev_dirty into the 2MB entry covering ev_vpn. Later lookups anywhere in that 2MB page report the merged bits on lk_acc and lk_dirty.
- R8: An eviction with ev_synth=0 ORs its bits into the 4KB entry with the same page number. An eviction that matches no entry of the kind it targets changes no stored state.
- R9: A fill whose kind and tag match a resident entry rewrites that entry in place and clears its accessed and dirty bits. Any other fill takes the slot under a round-robin pointer that starts at 0 and advances by one per new allocation, wrapping after ENTRIES.
- R10: A fill of kind 3 writes nothing and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | 4KB virtual page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | 4KB physical page number for the L1 fill |
| lk_synth | output | 1 | Result was synthesized from a 2MB entry |
| lk_acc | output | 1 | Accessed bit of the entry that produced the hit |
| lk_dirty | output | 1 | Dirty bit of the entry that produced the hit |
| fl_valid | input | 1 | Walker fill strobe |
| fl_kind | input | 2 | 0 = 4KB, 1 = 2MB, 2 = hole slice, 3 = none |
| fl_vpn | input | VPN_W | Page number (tag) of the fill |
| fl_data | input | DATA_W | PPN for translations, hole bits for a slice |
| ev_valid | input | 1 | L1 eviction strobe |
| ev_vpn | input | VPN_W | Page number of the evicted L1 entry |
| ev_synth | input | 1 | Evicted entry was synthesized |
| ev_acc | input | 1 | Evicted accessed bit |
| ev_dirty | input | 1 | Evicted dirty bit |

## Verification
A corrupted hole slice or a mis-tagged entry shows at the ports at once. The next combinational lookup in the affected 2MB page either hits where it should miss or returns the wrong 4KB base. A wrong round-robin pointer or a misdirected write is harder to catch: it stays hidden until a later fill overwrites a live entry. The bench therefore wraps the pointer and checks exactly which translation disappears. A lost accessed/dirty merge shows only on the next lookup of that page, so every eviction is followed by lookups on both the merged page and a page that must be left untouched.

// File: rtl/dual_tlb_pkg.sv
package dual_tlb_pkg;
   typedef enum logic [1:0] {
      KIND_4K   = 2'd0,
      KIND_2M   = 2'd1,
      KIND_VEC  = 2'd2,
      KIND_NONE = 2'd3
   } ent_kind_e;
endpackage

// File: rtl/dual_tlb_probe.sv
module dual_tlb_probe
   import dual_tlb_pkg::*;
#(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int HS    = 9,
   parameter int SB    = 5
) (
   input  logic [VPN_W-1:0]          vpn,
   input  logic [N-1:0]              valid,
   input  logic [N-1:0][1:0]         kind,
   input  logic [N-1:0][VPN_W-1:0]   tag,
   output logic [N-1:0]              m4,
   output logic [N-1:0]              m2,
   output logic [N-1:0]              mv
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign m4[i] = valid[i] && (kind[i] == KIND_4K)  && (tag[i] == vpn);
      assign m2[i] = valid[i] && (kind[i] == KIND_2M)  && (tag[i][VPN_W-1:HS] == vpn[VPN_W-1:HS]);
      assign mv[i] = valid[i] && (kind[i] == KIND_VEC) && (tag[i][VPN_W-1:SB] == vpn[VPN_W-1:SB]);
   end
endmodule

// File: rtl/dual_tlb_resolve.sv
module dual_tlb_resolve #(
   parameter int N      = 8,
   parameter int PPN_W  = 20,
   parameter int DATA_W = 32,
   parameter int SLICE_W = 32,
   parameter int HS     = 9,
   parameter int SB     = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lk_valid,
   input  logic [HS-1:0]             page_off,
   input  logic [N-1:0]              m4,
   input  logic [N-1:0]              m2,
   input  logic [N-1:0]              mv,
   input  logic [N-1:0][DATA_W-1:0]  data,
   input  logic [N-1:0]              acc,
   input  logic [N-1:0]              dirty,
   output logic                      hit,
   output logic [PPN_W-1:0]          ppn,
   output logic                      synth,
   output logic                      a_out,
   output logic                      d_out
);
   logic [PPN_W-1:0]    ppn4;
   logic [PPN_W-HS-1:0] base2;
   logic [SLICE_W-1:0]  vsel;
   logic                a4, d4, a2, d2;
   logic                any4, any2, anyv, hole;

   always_comb begin
      ppn4 = '0; base2 = '0; vsel = '0;
      a4 = 1'b0; d4 = 1'b0; a2 = 1'b0; d2 = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (m4[i]) begin
            ppn4 = data[i][PPN_W-1:0];
            a4   = acc[i];
            d4   = dirty[i];
         end
         if (m2[i]) begin
            base2 = data[i][PPN_W-1:HS];
            a2    = acc[i];
            d2    = dirty[i];
         end
         if (mv[i]) vsel = data[i][SLICE_W-1:0];
      end
   end

   assign any4 = |m4;
   assign any2 = |m2;
   assign anyv = |mv;
   assign hole = vsel[page_off[SB-1:0]];

   always_comb begin
      hit = 1'b0; ppn = '0; synth = 1'b0; a_out = 1'b0; d_out = 1'b0;
      if (lk_valid) begin
         if (any4) begin
            hit = 1'b1; ppn = ppn4; a_out = a4; d_out = d4;
         end else if (any2 && anyv && !hole) begin
            hit = 1'b1; synth = 1'b1; ppn = {base2, page_off};
            a_out = a2; d_out = d2;
         end
      end
   end

   assert_small_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && any4) |-> (hit && !synth));
   assert_no_slice_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !any4 && !anyv) |-> !hit);
   assert_synth_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && synth) |-> (ppn[HS-1:0] == page_off));
   assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (ppn == '0 && !synth && !a_out && !d_out));
endmodule

// File: rtl/dual_tlb_store.sv
module dual_tlb_store
   import dual_tlb_pkg::*;
#(
   parameter int N      = 8,
   parameter int VPN_W  = 20,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fl_valid,
   input  logic [1:0]                fl_kind,
   input  logic [VPN_W-1:0]          fl_vpn,
   input  logic [DATA_W-1:0]         fl_data,
   input  logic [N-1:0]              fl_match,
   input  logic                      ev_valid,
   input  logic                      ev_synth,
   input  logic                      ev_acc,
   input  logic                      ev_dirty,
   input  logic [N-1:0]              ev_m4,
   input  logic [N-1:0]              ev_m2,
   output logic [N-1:0]              valid,
   output logic [N-1:0][1:0]         kind,
   output logic [N-1:0][VPN_W-1:0]   tag,
   output logic [N-1:0][DATA_W-1:0]  data,
   output logic [N-1:0]              acc,
   output logic [N-1:0]              dirty
);
   localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

   logic [PTR_W-1:0] ptr;
   logic [PTR_W-1:0] widx;
   logic             fill_write, fill_hit;
   logic [N-1:0]     ev_sel;

   assign fill_write = fl_valid && (fl_kind != KIND_NONE);
   assign fill_hit   = |fl_match;
   assign ev_sel     = ev_valid ? (ev_synth ? ev_m2 : ev_m4) : '0;

   always_comb begin
      widx = ptr;
      for (int i = N - 1; i >= 0; i--)
         if (fl_match[i]) widx = PTR_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= '0;
         kind  <= '0;
         tag   <= '0;
         data  <= '0;
         acc   <= '0;
         dirty <= '0;
         ptr   <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (ev_sel[i]) begin
               acc[i]   <= acc[i] | ev_acc;
               dirty[i] <= dirty[i] | ev_dirty;
            end
         end
         if (fill_write) begin
            valid[widx] <= 1'b1;
            kind[widx]  <= fl_kind;
            tag[widx]   <= fl_vpn;
            data[widx]  <= fl_data;
            acc[widx]   <= 1'b0;
            dirty[widx] <= 1'b0;
            if (!fill_hit)
               ptr <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
         end
      end
   end

   assert_fill_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_write |=> (valid[$past(widx)] && tag[$past(widx)] == $past(fl_vpn)
                      && !acc[$past(widx)]));
   assert_ad_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_write |=> (($past(acc) & ~acc) == '0 && ($past(dirty) & ~dirty) == '0));
   assert_null_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && fl_kind == KIND_NONE) |=> $stable(ptr));
endmodule

// File: rtl/dual_l2_tlb.sv
module dual_l2_tlb
   import dual_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int HS      = 9,
   parameter int SLICE_W = 32,
   localparam int SB     = $clog2(SLICE_W),
   localparam int DATA_W = (PPN_W > SLICE_W) ? PPN_W : SLICE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic              lk_synth,
   output logic              lk_acc,
   output logic              lk_dirty,
   input  logic              fl_valid,
   input  logic [1:0]        fl_kind,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [DATA_W-1:0] fl_data,
   input  logic              ev_valid,
   input  logic [VPN_W-1:0]  ev_vpn,
   input  logic              ev_synth,
   input  logic              ev_acc,
   input  logic              ev_dirty
);
   if (ENTRIES < 2) begin : g_bad_n
      $error("ENTRIES must be at least 2");
   end
   if ((SLICE_W & (SLICE_W - 1)) != 0 || SB > HS) begin : g_bad_slice
      $error("SLICE_W must be a power of two no wider than a 2MB page");
   end
   if (PPN_W <= HS || VPN_W <= HS) begin : g_bad_width
      $error("page number widths must exceed the huge-page shift");
   end

   logic [ENTRIES-1:0]              valid, acc, dirty;
   logic [ENTRIES-1:0][1:0]         kind;
   logic [ENTRIES-1:0][VPN_W-1:0]   tag;
   logic [ENTRIES-1:0][DATA_W-1:0]  data;
   logic [ENTRIES-1:0] lm4, lm2, lmv, fm4, fm2, fmv, em4, em2, emv;
   logic [ENTRIES-1:0] fl_match;

   dual_tlb_probe #(.N(ENTRIES), .VPN_W(VPN_W), .HS(HS), .SB(SB)) u_lk_probe (
      .vpn(lk_vpn), .valid(valid), .kind(kind), .tag(tag), .m4(lm4), .m2(lm2), .mv(lmv));
   dual_tlb_probe #(.N(ENTRIES), .VPN_W(VPN_W), .HS(HS), .SB(SB)) u_fl_probe (
      .vpn(fl_vpn), .valid(valid), .kind(kind), .tag(tag), .m4(fm4), .m2(fm2), .mv(fmv));
   dual_tlb_probe #(.N(ENTRIES), .VPN_W(VPN_W), .HS(HS), .SB(SB)) u_ev_probe (
      .vpn(ev_vpn), .valid(valid), .kind(kind), .tag(tag), .m4(em4), .m2(em2), .mv(emv));

   always_comb begin
      case (fl_kind)
         KIND_4K:  fl_match = fm4;
         KIND_2M:  fl_match = fm2;
         KIND_VEC: fl_match = fmv;
         default:  fl_match = '0;
      endcase
   end

   dual_tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .fl_valid(fl_valid), .fl_kind(fl_kind), .fl_vpn(fl_vpn), .fl_data(fl_data),
      .fl_match(fl_match),
      .ev_valid(ev_valid), .ev_synth(ev_synth), .ev_acc(ev_acc), .ev_dirty(ev_dirty),
      .ev_m4(em4), .ev_m2(em2),
      .valid(valid), .kind(kind), .tag(tag), .data(data), .acc(acc), .dirty(dirty));

   dual_tlb_resolve #(.N(ENTRIES), .PPN_W(PPN_W), .DATA_W(DATA_W), .SLICE_W(SLICE_W),
                      .HS(HS), .SB(SB)) u_resolve (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .page_off(lk_vpn[HS-1:0]),
      .m4(lm4), .m2(lm2), .mv(lmv), .data(data), .acc(acc), .dirty(dirty),
      .hit(lk_hit), .ppn(lk_ppn), .synth(lk_synth), .a_out(lk_acc), .d_out(lk_dirty));

   assert_unique_small_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lm4));
   assert_unique_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lmv));
   assert_unused_evict_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_synth && em4 == '0 && !fl_valid) |=> ($stable(acc) && $stable(dirty)));
endmodule

// File: tb/dual_l2_tlb_bench.sv
module dual_l2_tlb_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic        lk_hit, lk_synth, lk_acc, lk_dirty;
   logic [19:0] lk_ppn;
   logic        fl_valid = 1'b0;
   logic [1:0]  fl_kind = '0;
   logic [19:0] fl_vpn = '0;
   logic [31:0] fl_data = '0;
   logic        ev_valid = 1'b0, ev_synth = 1'b0, ev_acc = 1'b0, ev_dirty = 1'b0;
   logic [19:0] ev_vpn = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dual_l2_tlb u_dual_l2_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .lk_synth(lk_synth), .lk_acc(lk_acc), .lk_dirty(lk_dirty),
      .fl_valid(fl_valid), .fl_kind(fl_kind), .fl_vpn(fl_vpn), .fl_data(fl_data),
      .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_synth(ev_synth),
      .ev_acc(ev_acc), .ev_dirty(ev_dirty));

   // op: 0 lookup, 1 fill 4KB, 2 fill 2MB, 3 fill slice, 4 fill kind 3, 5 evict
   // evict data: bit0 acc, bit1 dirty, bit2 synth
   // fields: op, vpn, data, exp_hit, exp_synth, exp_ppn, exp_acc, exp_dirty, req
   localparam int NV = 31;
   localparam logic [82:0] VEC [NV] = '{
      {3'd1, 20'h00010, 32'h000000AB, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd2},
      {3'd0, 20'h00010, 32'h0,        1'b1,1'b0,20'h000AB,1'b0,1'b0, 4'd2},  // R2
      {3'd0, 20'h00011, 32'h0,        1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd2},  // R2
      {3'd2, 20'h00200, 32'h00040000, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd4},
      {3'd0, 20'h00234, 32'h0,        1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd6},  // R6
      {3'd3, 20'h00220, 32'h00000010, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd4},
      {3'd0, 20'h00223, 32'h0,        1'b1,1'b1,20'h40023,1'b0,1'b0, 4'd4},  // R4
      {3'd0, 20'h0022F, 32'h0,        1'b1,1'b1,20'h4002F,1'b0,1'b0, 4'd5},  // R5
      {3'd0, 20'h00224, 32'h0,        1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd6},  // R6
      {3'd1, 20'h00224, 32'h00007777, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd3},
      {3'd0, 20'h00224, 32'h0,        1'b1,1'b0,20'h07777,1'b0,1'b0, 4'd3},  // R3
      {3'd1, 20'h00225, 32'h00001234, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd3},
      {3'd0, 20'h00225, 32'h0,        1'b1,1'b0,20'h01234,1'b0,1'b0, 4'd3},  // R3
      {3'd0, 20'h00245, 32'h0,        1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd6},  // R6
      {3'd5, 20'h00223, 32'h00000005, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd7},
      {3'd0, 20'h00223, 32'h0,        1'b1,1'b1,20'h40023,1'b1,1'b0, 4'd7},  // R7
      {3'd0, 20'h0022F, 32'h0,        1'b1,1'b1,20'h4002F,1'b1,1'b0, 4'd7},  // R7
      {3'd0, 20'h00225, 32'h0,        1'b1,1'b0,20'h01234,1'b0,1'b0, 4'd7},  // R7
      {3'd5, 20'h00010, 32'h00000003, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd8},
      {3'd0, 20'h00010, 32'h0,        1'b1,1'b0,20'h000AB,1'b1,1'b1, 4'd8},  // R8
      {3'd5, 20'h00099, 32'h00000003, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd8},
      {3'd0, 20'h00224, 32'h0,        1'b1,1'b0,20'h07777,1'b0,1'b0, 4'd8},  // R8
      {3'd5, 20'h00600, 32'h00000006, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd8},
      {3'd5, 20'h00226, 32'h00000002, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd8},
      {3'd0, 20'h00223, 32'h0,        1'b1,1'b1,20'h40023,1'b1,1'b0, 4'd8},  // R8
      {3'd1, 20'h00010, 32'h000000CD, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd9},
      {3'd0, 20'h00010, 32'h0,        1'b1,1'b0,20'h000CD,1'b0,1'b0, 4'd9},  // R9
      {3'd4, 20'h00050, 32'h00000050, 1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd10},
      {3'd0, 20'h00050, 32'h0,        1'b0,1'b0,20'h00000,1'b0,1'b0, 4'd10}, // R10
      {3'd0, 20'h00220, 32'h0,        1'b1,1'b1,20'h40020,1'b1,1'b0, 4'd5},  // R5
      {3'd0, 20'h00010, 32'h0,        1'b1,1'b0,20'h000CD,1'b0,1'b0, 4'd9}   // R9
   };

   task automatic look(input logic [19:0] vpn, input logic eh, input logic es,
                       input logic [19:0] ep, input logic ea, input logic ed, input int req);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_vpn   = vpn;
      #1;
      checks++;
      if (lk_hit !== eh || lk_synth !== es || lk_ppn !== ep || lk_acc !== ea || lk_dirty !== ed) begin
         fails++;
         $display("FAIL R%0d vpn=%h actual hit=%b syn=%b ppn=%h a=%b d=%b expected hit=%b syn=%b ppn=%h a=%b d=%b",
                  req, vpn, lk_hit, lk_synth, lk_ppn, lk_acc, lk_dirty, eh, es, ep, ea, ed);
      end
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [1:0] k, input logic [19:0] vpn, input logic [31:0] d);
      @(negedge clk);
      fl_valid = 1'b1; fl_kind = k; fl_vpn = vpn; fl_data = d;
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   task automatic evict(input logic [19:0] vpn, input logic [2:0] f);
      @(negedge clk);
      ev_valid = 1'b1; ev_vpn = vpn; ev_acc = f[0]; ev_dirty = f[1]; ev_synth = f[2];
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: nothing resident after reset
      look(20'h12345, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1);
      look(20'h00000, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1);
      rst_n = 1'b1;
      look(20'h00010, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1);

      for (int i = 0; i < NV; i++) begin
         logic [82:0] v;
         v = VEC[i];
         case (v[82:80])
            3'd0: look(v[79:60], v[27], v[26], v[25:6], v[5], v[4], int'(v[3:0]));
            3'd1: fill(2'd0, v[79:60], v[59:28]);
            3'd2: fill(2'd1, v[79:60], v[59:28]);
            3'd3: fill(2'd2, v[79:60], v[59:28]);
            3'd4: fill(2'd3, v[79:60], v[59:28]);
            default: evict(v[79:60], v[30:28]);
         endcase
      end

      // R9: slots 0..4 used, pointer at 5; four new fills wrap onto slot 0
      for (int i = 0; i < 4; i++) fill(2'd0, 20'h01000 + 20'(i), 32'h500 + 32'(i));
      look(20'h00010, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 9);
      look(20'h01000, 1'b1, 1'b0, 20'h00500, 1'b0, 1'b0, 9);
      look(20'h01003, 1'b1, 1'b0, 20'h00503, 1'b0, 1'b0, 9);
      look(20'h00223, 1'b1, 1'b1, 20'h40023, 1'b1, 1'b0, 9);
      fill(2'd0, 20'h01004, 32'h504);
      look(20'h00223, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 9);
      look(20'h00224, 1'b1, 1'b0, 20'h07777, 1'b0, 1'b0, 9);
      look(20'h01004, 1'b1, 1'b0, 20'h00504, 1'b0, 1'b0, 9);

      // R1: reset clears every entry
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look(20'h00224, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1);
      look(20'h01004, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R0 watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule